// File: doc/BRIEF.md
# Fetch Next-Address Predictor with Target Cache and Return Stack

This block sits beside the fetch stage and picks the address to fetch after the current one, within the same cycle. It has two sources of redirect. The first is a small direct-mapped cache of targets seen on earlier taken branches and jumps. The second is a circular stack of return addresses. A return pulls its address from the stack. When a cached target is found, the external direction predictor decides whether it is used. If that predictor has no history for the branch, the block falls back to a static rule: a target below the fetch address is taken, and one above it is not.

The resolution logic writes targets through an update port. The fetch-side decode marks calls and returns. A flush input wipes every cached target and empties the stack when speculation turns out wrong.

Top module: `nextpc_predictor`

## Requirements
- R1: When the fetch PC hits a valid entry with a matching tag and `dir_valid` is 1, `next_pc` is the stored target if `dir_taken` is 1, and `fetch_pc + 4` if `dir_taken` is 0.
- R2: When the fetch PC misses (`btb_hit` is 0) and `f_ret` is 0, `next_pc` is `fetch_pc + 4`.
- R3: On a hit with `dir_valid` 0, `next_pc` is the stored target if that target is below `fetch_pc` (unsigned), and `fetch_pc + 4` otherwise.
- R4: A cycle with `f_call` 1 pushes `fetch_pc + 4`. A cycle with `f_ret` 1 and a non-empty stack gives the top entry as `next_pc` and pops it, in last-in first-out order.
- R5: `f_ret` on an empty stack gives `fetch_pc + 4` and leaves the stack unchanged.
- R6: The stack holds 2^RAS_AW entries. A push onto a full stack discards the oldest entry, so a later run of pops returns only the newest 2^RAS_AW addresses.
- R7: `f_ret` takes precedence over a cache hit. When `f_call` and `f_ret` are both 1 in one cycle, only the return acts.
- R8: An update writes valid, tag `upd_pc[XLEN-1:IDX_W+2]` and target into entry `upd_pc[IDX_W+1:2]`. The entry is visible from the next cycle. A later update to the same index with a different tag replaces it.
- R9: `flush` clears all valid bits and empties the stack at the next edge. It overrides an update, a push or a pop in the same cycle.
- R10: After reset, every fetch misses and the stack is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| fetch_pc | input | XLEN | Address being fetched |
| dir_valid | input | 1 | Direction predictor has history for this fetch |
| dir_taken | input | 1 | Direction prediction, used when dir_valid is 1 |
| f_call | input | 1 | Fetched instruction is a call |
| f_ret | input | 1 | Fetched instruction is a return |
| upd_valid | input | 1 | Install a resolved target |
| upd_pc | input | XLEN | Address of the resolved branch or jump |
| upd_target | input | XLEN | Its resolved target |
| flush | input | 1 | Discard cached targets and stack contents |
| next_pc | output | XLEN | Predicted next fetch address |
| btb_hit | output | 1 | Fetch PC found in the target cache |

## Verification
The bench builds the block with IDX_W = 2 and RAS_AW = 2, which gives a four-entry cache and a four-deep stack. At that size every cache index can be filled with either a backward or a forward target and then swept over all three direction-input cases. The stack can be driven past full and then drained to empty within a few dozen cycles. Tag aliasing is reached by adding 16 to a PC, and flush is tested against a simultaneous update and push.

// File: rtl/nextpc_predictor.sv
module nextpc_predictor #(
  parameter int XLEN   = 32,
  parameter int IDX_W  = 4,
  parameter int RAS_AW = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [XLEN-1:0] fetch_pc,
  input  logic            dir_valid,
  input  logic            dir_taken,
  input  logic            f_call,
  input  logic            f_ret,
  input  logic            upd_valid,
  input  logic [XLEN-1:0] upd_pc,
  input  logic [XLEN-1:0] upd_target,
  input  logic            flush,
  output logic [XLEN-1:0] next_pc,
  output logic            btb_hit
);
  localparam int ENTRIES = 1 << IDX_W;
  localparam int TAG_W   = XLEN - IDX_W - 2;
  localparam int RAS_D   = 1 << RAS_AW;

  logic [ENTRIES-1:0] vld_q;
  logic [TAG_W-1:0]   tag_q [ENTRIES];
  logic [XLEN-1:0]    tgt_q [ENTRIES];
  logic [XLEN-1:0]    ras_q [RAS_D];
  logic [RAS_AW-1:0]  top_q;
  logic [RAS_AW:0]    cnt_q;

  logic [IDX_W-1:0] f_idx, u_idx;
  logic [XLEN-1:0]  seq_pc, hit_tgt;
  logic             take, ras_has, pop, push;

  assign f_idx   = fetch_pc[IDX_W+1:2];
  assign u_idx   = upd_pc[IDX_W+1:2];
  assign seq_pc  = fetch_pc + XLEN'(4);
  assign hit_tgt = tgt_q[f_idx];
  assign btb_hit = vld_q[f_idx] && (tag_q[f_idx] == fetch_pc[XLEN-1:IDX_W+2]);
  assign take    = btb_hit && (dir_valid ? dir_taken : (hit_tgt < fetch_pc));
  assign ras_has = cnt_q != '0;
  assign pop     = f_ret && ras_has;
  assign push    = f_call && !f_ret;

  assign next_pc = f_ret ? (ras_has ? ras_q[top_q] : seq_pc)
                         : (take ? hit_tgt : seq_pc);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)         vld_q <= '0;
    else if (flush)     vld_q <= '0;
    else if (upd_valid) vld_q[u_idx] <= 1'b1;

  always_ff @(posedge clk)
    if (upd_valid && !flush) begin
      tag_q[u_idx] <= upd_pc[XLEN-1:IDX_W+2];
      tgt_q[u_idx] <= upd_target;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      top_q <= '0;
      cnt_q <= '0;
    end else if (flush) begin
      top_q <= '0;
      cnt_q <= '0;
    end else if (pop) begin
      top_q <= top_q - 1'b1;
      cnt_q <= cnt_q - 1'b1;
    end else if (push) begin
      top_q <= top_q + 1'b1;
      if (cnt_q != (RAS_AW+1)'(RAS_D)) cnt_q <= cnt_q + 1'b1;
    end

  always_ff @(posedge clk)
    if (push && !flush) ras_q[top_q + 1'b1] <= seq_pc;
endmodule

// File: rtl/nextpc_predictor_chk.sv
module nextpc_predictor_chk #(
  parameter int XLEN   = 32,
  parameter int IDX_W  = 4,
  parameter int RAS_AW = 3
) (
  input logic            clk,
  input logic            rst_n,
  input logic [XLEN-1:0] fetch_pc,
  input logic            dir_valid,
  input logic            dir_taken,
  input logic            f_call,
  input logic            f_ret,
  input logic            upd_valid,
  input logic [XLEN-1:0] upd_pc,
  input logic [XLEN-1:0] upd_target,
  input logic            flush,
  input logic [XLEN-1:0] next_pc,
  input logic            btb_hit
);
  // R2
  miss_seq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!btb_hit && !f_ret) |-> next_pc == fetch_pc + XLEN'(4));

  // R8
  install_seen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_valid && !flush) |=>
      (!(fetch_pc == $past(upd_pc) && dir_valid && dir_taken && !f_ret) ||
       (btb_hit && next_pc == $past(upd_target))));

  // R4
  call_ret_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (f_call && !f_ret && !flush) |=> (!f_ret || next_pc == $past(fetch_pc) + XLEN'(4)));

  // R9
  flush_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> !btb_hit);

  // R9
  flush_empties_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (!f_ret || next_pc == fetch_pc + XLEN'(4)));
endmodule

bind nextpc_predictor nextpc_predictor_chk #(.XLEN(XLEN), .IDX_W(IDX_W), .RAS_AW(RAS_AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .fetch_pc(fetch_pc), .dir_valid(dir_valid),
  .dir_taken(dir_taken), .f_call(f_call), .f_ret(f_ret), .upd_valid(upd_valid),
  .upd_pc(upd_pc), .upd_target(upd_target), .flush(flush),
  .next_pc(next_pc), .btb_hit(btb_hit)
);

// File: tb/test_nextpc_predictor.sv
`timescale 1ns/1ps
module test_nextpc_predictor;
  localparam int XLEN = 32, IDX_W = 2, RAS_AW = 2, NE = 4, ND = 4;

  logic clk = 0, rst_n = 0;
  logic [XLEN-1:0] fetch_pc = 0, upd_pc = 0, upd_target = 0, next_pc;
  logic dir_valid = 0, dir_taken = 0, f_call = 0, f_ret = 0, upd_valid = 0, flush = 0, btb_hit;
  int vecs = 0, errs = 0;
  bit done = 0;

  bit        mv [NE];
  logic [31:0] mpc [NE], mtg [NE], ms [ND];
  int mcnt = 0;

  always #4 clk = ~clk;

  nextpc_predictor #(.XLEN(XLEN), .IDX_W(IDX_W), .RAS_AW(RAS_AW)) i_nextpc_predictor (
    .clk(clk), .rst_n(rst_n), .fetch_pc(fetch_pc), .dir_valid(dir_valid),
    .dir_taken(dir_taken), .f_call(f_call), .f_ret(f_ret), .upd_valid(upd_valid),
    .upd_pc(upd_pc), .upd_target(upd_target), .flush(flush),
    .next_pc(next_pc), .btb_hit(btb_hit));

  task automatic cyc(input logic [31:0] pc, input bit call, input bit ret, input bit dv,
                     input bit dt, input bit uv, input logic [31:0] upc,
                     input logic [31:0] utg, input bit fl, input string req);
    logic [31:0] exp_pc;
    bit exp_hit;
    int i;
    fetch_pc = pc; f_call = call; f_ret = ret; dir_valid = dv; dir_taken = dt;
    upd_valid = uv; upd_pc = upc; upd_target = utg; flush = fl;
    #1;
    i = int'(pc[3:2]);
    exp_hit = mv[i] && (mpc[i][31:4] == pc[31:4]);
    exp_pc = pc + 32'd4;
    if (ret) begin
      if (mcnt > 0) exp_pc = ms[0];
    end else if (exp_hit && (dv ? dt : (mtg[i] < pc))) exp_pc = mtg[i];
    vecs++;
    if (next_pc !== exp_pc) begin
      errs++;
      $display("FAIL %s next_pc pc=%h got %h exp %h", req, pc, next_pc, exp_pc);
    end
    vecs++;
    if (btb_hit !== exp_hit) begin
      errs++;
      $display("FAIL %s btb_hit pc=%h got %b exp %b", req, pc, btb_hit, exp_hit);
    end
    @(posedge clk);
    if (fl) begin
      for (int k = 0; k < NE; k++) mv[k] = 0;
      mcnt = 0;
    end else begin
      if (uv) begin mv[upc[3:2]] = 1; mpc[upc[3:2]] = upc; mtg[upc[3:2]] = utg; end
      if (ret) begin
        if (mcnt > 0) begin
          for (int k = 0; k < ND-1; k++) ms[k] = ms[k+1];
          mcnt--;
        end
      end else if (call) begin
        for (int k = ND-1; k > 0; k--) ms[k] = ms[k-1];
        ms[0] = pc + 32'd4;
        if (mcnt < ND) mcnt++;
      end
    end
    @(negedge clk);
  endtask

  task automatic fetch(input logic [31:0] pc, input bit dv, input bit dt, input string req);
    cyc(pc, 0, 0, dv, dt, 0, 0, 0, 0, req);
  endtask

  task automatic install(input logic [31:0] pc, input logic [31:0] tg, input string req);
    cyc(32'h9000, 0, 0, 0, 0, 1, pc, tg, 0, req);
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  endtask

  initial begin
    #(200000 * 8);
    if (!done) begin
      errs++;
      $display("FAIL watchdog expired");
      finish_run();
    end
  end

  initial begin
    for (int k = 0; k < NE; k++) mv[k] = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1;

    // R10 reset state: every index misses, empty stack
    for (int i = 0; i < NE; i++) fetch(32'h100 + 32'(i*4), 1, 1, "R10");
    // R5 return on empty stack
    cyc(32'h180, 0, 1, 0, 0, 0, 0, 0, 0, "R5");

    // R8 install all entries: even index backward target, odd forward
    for (int i = 0; i < NE; i++)
      install(32'h100 + 32'(i*4), (i % 2 == 0) ? 32'h40 + 32'(i*4) : 32'h800 + 32'(i*4), "R8");
    // R1 and R3: sweep all entries over three direction cases
    for (int i = 0; i < NE; i++) begin
      fetch(32'h100 + 32'(i*4), 1, 1, "R1");
      fetch(32'h100 + 32'(i*4), 1, 0, "R1");
      fetch(32'h100 + 32'(i*4), 0, 0, "R3");
    end
    // R2 and R8 aliasing: same index, different tag
    for (int i = 0; i < NE; i++) fetch(32'h110 + 32'(i*4), 1, 1, "R2");
    install(32'h114, 32'h20, "R8");
    fetch(32'h114, 1, 1, "R8");
    fetch(32'h104, 1, 1, "R8");

    // R4 LIFO
    cyc(32'h200, 1, 0, 0, 0, 0, 0, 0, 0, "R4");
    cyc(32'h300, 1, 0, 0, 0, 0, 0, 0, 0, "R4");
    cyc(32'h400, 1, 0, 0, 0, 0, 0, 0, 0, "R4");
    for (int i = 0; i < 3; i++) cyc(32'h500, 0, 1, 0, 0, 0, 0, 0, 0, "R4");
    cyc(32'h500, 0, 1, 0, 0, 0, 0, 0, 0, "R5");

    // R6 overflow: six pushes, four pops, then empty
    for (int i = 0; i < 6; i++) cyc(32'h1000 + 32'(i*16), 1, 0, 0, 0, 0, 0, 0, 0, "R6");
    for (int i = 0; i < 5; i++) cyc(32'h2000, 0, 1, 0, 0, 0, 0, 0, 0, "R6");

    // R7 return beats a taken hit; call and return together acts as return only
    cyc(32'h600, 1, 0, 0, 0, 0, 0, 0, 0, "R7");
    cyc(32'h100, 0, 1, 1, 1, 0, 0, 0, 0, "R7");
    cyc(32'h700, 1, 0, 0, 0, 0, 0, 0, 0, "R7");
    cyc(32'h710, 1, 1, 0, 0, 0, 0, 0, 0, "R7");
    cyc(32'h720, 0, 1, 0, 0, 0, 0, 0, 0, "R7");

    // R9 flush with concurrent update and push
    cyc(32'h800, 1, 0, 0, 0, 0, 0, 0, 0, "R9");
    cyc(32'h900, 1, 0, 0, 0, 1, 32'h10c, 32'h0, 1, "R9");
    for (int i = 0; i < NE; i++) fetch(32'h100 + 32'(i*4), 1, 1, "R9");
    cyc(32'h114, 0, 1, 0, 0, 0, 0, 0, 0, "R9");
    fetch(32'h10c, 0, 0, "R9");

    done = 1;
    finish_run();
  end
endmodule